// File: doc/BRIEF.md
# Forwarded-Clock 1:7 Deserializer, Three Data Lanes

This block sits behind a set of serial receivers that deliver three data lanes and one forwarded-clock lane, all sampled by one fast clock running at seven times the word rate. Each word period carries seven slots per lane. The block shifts in every lane, finds the word boundary by watching the clock lane for its fixed high/low shape, and rebuilds a 21-bit parallel word once per period.

The rebuilt word is presented together with a regenerated word-rate clock and a valid flag. A lock flag shows that the boundary has been confirmed on consecutive periods. An active-low power-down input freezes the presented word and word clock and drops lock. After power-down ends, valid stays low until the boundary has been confirmed again. Skew between lanes is not compensated. The fast clock comes from outside the block.

Top module: `fwd_deser21`

## Requirements
- R1: Slot k of each word period (k = 0..6, slot 0 first in time) carries bit k of a lane. Lane L fills output bits 7L+k, so lane 0 fills bits 0-6, lane 1 fills bits 7-13 and lane 2 fills bits 14-20.
- R2: A period is aligned when the seven clock-lane samples of that period, in slot order 0..6, read 1,1,0,0,0,1,1. Lock is declared only through such periods.
- R3: The first aligned period found while hunting gives neither lock nor valid. The second aligned period in a row sets `locked_o` and delivers that second word with `word_vld_o` high.
- R4: While locked, one misaligned period keeps lock, delivers no word and leaves `word_o` unchanged. A second misaligned period in a row drops lock.
- R5: A word is presented on `word_o` at the fast-clock edge that samples slot 0 of the following period. `word_vld_o` is high for exactly the seven fast cycles that follow a delivery, and low for periods that deliver nothing.
- R6: While locked or confirming, `word_clk_o` is high for four fast cycles and low for three fast cycles. It rises on the same edge that presents a new word. It stays low while hunting.
- R7: While `pwr_n` is low, `word_o` and `word_clk_o` keep the values they had when power-down began, and `locked_o` and `word_vld_o` are low.
- R8: After `pwr_n` returns high, `word_vld_o` stays low until two aligned periods in a row have been seen again.
- R9: After synchronous reset, `word_o`, `word_clk_o`, `word_vld_o` and `locked_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, seven cycles per word period |
| rst | input | 1 | Synchronous active-high reset |
| pwr_n | input | 1 | Active-low power-down: outputs frozen, lock dropped |
| ser_lane_i | input | 3 | Serial data lanes, one bit per fast cycle |
| fwd_clk_lane_i | input | 1 | Forwarded-clock lane sample |
| word_o | output | 21 | Rebuilt parallel word |
| word_clk_o | output | 1 | Regenerated word-rate clock |
| word_vld_o | output | 1 | High during the period after a word delivery |
| locked_o | output | 1 | Word boundary confirmed |

## Verification
The hardest situation to reach from the ports is power-down that begins mid-period while the block is locked. The frozen word clock then holds whatever phase it had. After release, the block must hunt again and suppress valid for two full periods. The bench contains a serializer model that raises and drops power-down at slot 1 of chosen periods, and inserts misaligned clock-lane periods one at a time and two in a row, both directed and at random. A period-level model of hunting, confirming and locking predicts the lock, valid, word clock and word at fixed slots of every period.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/lane_shifter.sv
// Shift register for one serial lane; the earliest slot ends in bit 0.
module lane_shifter #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_i,
  output logic [SLOTS-1:0] par_o
);
  always_ff @(posedge clk) begin
    if (rst) par_o <= '0;
    else     par_o <= {ser_i, par_o[SLOTS-1:1]};
  end
endmodule

// File: rtl/frame_tracker.sv
// Boundary search, confirmation and flywheel over the clock-lane window.
module frame_tracker
  import fdr_pkg::*;
#(
  parameter int               SLOTS       = 7,
  parameter logic [SLOTS-1:0] CLK_PAT     = 7'b1100011,
  parameter int               LOCK_HITS   = 2,
  parameter int               DROP_MISSES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_n,
  input  logic [SLOTS-1:0] win_i,
  output logic             cap_o,
  output logic             seg_end_o,
  output logic             wclk_nxt_o,
  output logic             locked_o
);
  localparam int CW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int HW   = $clog2(LOCK_HITS + 1);
  localparam int MW   = $clog2(DROP_MISSES + 1);
  localparam int HIGH = (SLOTS + 1) / 2;

  trk_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] hits_q, hits_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          match, boundary;

  assign match    = (win_i == CLK_PAT);
  assign boundary = (state_q != ST_HUNT) && (cnt_q == CW'(SLOTS - 1));

  always_comb begin
    state_d = state_q;
    hits_d  = hits_q;
    miss_d  = miss_q;
    cap_o   = 1'b0;
    cnt_d   = (cnt_q == CW'(SLOTS - 1)) ? '0 : cnt_q + CW'(1);
    if (!pwr_n) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      hits_d  = '0;
      miss_d  = '0;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          cnt_d = '0;
          if (match) begin
            state_d = ST_CONFIRM;
            hits_d  = HW'(1);
          end
        end
        ST_CONFIRM: begin
          if (boundary) begin
            if (!match) begin
              state_d = ST_HUNT;
              hits_d  = '0;
            end else if ((hits_q + HW'(1)) >= HW'(LOCK_HITS)) begin
              state_d = ST_LOCKED;
              miss_d  = '0;
              cap_o   = 1'b1;
            end else begin
              hits_d = hits_q + HW'(1);
            end
          end
        end
        ST_LOCKED: begin
          if (boundary) begin
            if (match) begin
              cap_o  = 1'b1;
              miss_d = '0;
            end else if ((miss_q + MW'(1)) >= MW'(DROP_MISSES)) begin
              state_d = ST_HUNT;
              miss_d  = '0;
              hits_d  = '0;
            end else begin
              miss_d = miss_q + MW'(1);
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  assign seg_end_o  = boundary && pwr_n;
  assign wclk_nxt_o = (state_d != ST_HUNT) && (cnt_d < CW'(HIGH));
  assign locked_o   = (state_q == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      hits_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hits_q  <= hits_d;
      miss_q  <= miss_d;
    end
  end
endmodule

// File: rtl/word_out_reg.sv
// Output register: word, regenerated clock and valid, frozen in power-down.
module word_out_reg #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_n,
  input  logic              cap_i,
  input  logic              seg_end_i,
  input  logic              wclk_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wclk_o,
  output logic              vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      wclk_o <= 1'b0;
      vld_o  <= 1'b0;
    end else if (!pwr_n) begin
      vld_o <= 1'b0;
    end else begin
      wclk_o <= wclk_i;
      if (cap_i)     word_o <= word_i;
      if (seg_end_i) vld_o  <= cap_i;
    end
  end
endmodule

// File: rtl/fwd_deser21.sv
module fwd_deser21 #(
  parameter int                 LANES       = 3,
  parameter int                 SLOTS       = 7,
  parameter logic [SLOTS-1:0]   CLK_PAT     = 7'b1100011,
  parameter int                 LOCK_HITS   = 2,
  parameter int                 DROP_MISSES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pwr_n,
  input  logic [LANES-1:0]         ser_lane_i,
  input  logic                     fwd_clk_lane_i,
  output logic [LANES*SLOTS-1:0]   word_o,
  output logic                     word_clk_o,
  output logic                     word_vld_o,
  output logic                     locked_o
);
  localparam int WORD_W = LANES * SLOTS;

  logic [WORD_W-1:0] word_raw;
  logic [SLOTS-1:0]  clk_win;
  logic              cap, seg_end, wclk_nxt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_shifter #(.SLOTS(SLOTS)) shf_i (
      .clk   (clk),
      .rst   (rst),
      .ser_i (ser_lane_i[l]),
      .par_o (word_raw[l*SLOTS +: SLOTS])
    );
  end

  lane_shifter #(.SLOTS(SLOTS)) clk_shf_i (
    .clk   (clk),
    .rst   (rst),
    .ser_i (fwd_clk_lane_i),
    .par_o (clk_win)
  );

  frame_tracker #(
    .SLOTS       (SLOTS),
    .CLK_PAT     (CLK_PAT),
    .LOCK_HITS   (LOCK_HITS),
    .DROP_MISSES (DROP_MISSES)
  ) trk_i (
    .clk        (clk),
    .rst        (rst),
    .pwr_n      (pwr_n),
    .win_i      (clk_win),
    .cap_o      (cap),
    .seg_end_o  (seg_end),
    .wclk_nxt_o (wclk_nxt),
    .locked_o   (locked_o)
  );

  word_out_reg #(.WORD_W(WORD_W)) out_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_n     (pwr_n),
    .cap_i     (cap),
    .seg_end_i (seg_end),
    .wclk_i    (wclk_nxt),
    .word_i    (word_raw),
    .word_o    (word_o),
    .wclk_o    (word_clk_o),
    .vld_o     (word_vld_o)
  );
endmodule

// File: rtl/fdr_checker.sv
module fdr_checker #(
  parameter int WORD_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_n,
  input logic [WORD_W-1:0] word_o,
  input logic              word_clk_o,
  input logic              word_vld_o,
  input logic              locked_o
);
  // R5: valid never stands without lock
  p_vld_locked_r5: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> locked_o);

  // R3: lock is gained on the same edge that delivers a word
  p_lock_delivers_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> word_vld_o);

  // R4: the word only changes along with a delivery
  p_word_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_o) |-> word_vld_o);

  // R6: a delivery starts with a rising word clock
  p_wclk_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(word_vld_o) |-> $rose(word_clk_o));

  // R7: power-down freezes word and word clock
  p_pd_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> ($stable(word_o) && $stable(word_clk_o)));

  // R7: power-down drops lock and valid
  p_pd_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> (!locked_o && !word_vld_o));
endmodule

bind fwd_deser21 fdr_checker #(.WORD_W(LANES*SLOTS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pwr_n      (pwr_n),
  .word_o     (word_o),
  .word_clk_o (word_clk_o),
  .word_vld_o (word_vld_o),
  .locked_o   (locked_o)
);

// File: tb/fwd_deser21_tb_top.sv
`timescale 1ns/1ps
module fwd_deser21_tb_top;
  localparam int LANES = 3;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;
  localparam logic [SLOTS-1:0] PAT = 7'b1100011;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pwr_n = 1'b1;
  logic [LANES-1:0] ser_lane_i = '0;
  logic           fwd_clk_lane_i = 1'b0;
  logic [W-1:0]   word_o;
  logic           word_clk_o, word_vld_o, locked_o;

  always #4 clk = ~clk;

  fwd_deser21 dut_i (
    .clk(clk), .rst(rst), .pwr_n(pwr_n), .ser_lane_i(ser_lane_i),
    .fwd_clk_lane_i(fwd_clk_lane_i), .word_o(word_o), .word_clk_o(word_clk_o),
    .word_vld_o(word_vld_o), .locked_o(locked_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // period-level model: 0 hunt, 1 confirm, 2 locked
  int           m_state = 0, m_miss = 0;
  logic [W-1:0] m_word = '0, prev_word = '0;
  bit           prev_good = 0, exp_vld = 0, recov = 0, pd_b = 0;
  logic         snap_wclk = 0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic clk_bit(input bit good, input int s);
    return good ? PAT[s] : 1'b1;
  endfunction

  task automatic model_step();
    int    old = m_state;
    bit    cap = 0;
    string tl, tv;
    if (pd_b) begin
      m_state = 0; m_miss = 0;
    end else begin
      case (m_state)
        0: if (prev_good) m_state = 1;
        1: if (prev_good) begin m_state = 2; cap = 1; m_miss = 0; end
           else m_state = 0;
        default: if (prev_good) begin cap = 1; m_miss = 0; end
                 else begin
                   m_miss++;
                   if (m_miss >= 2) begin m_state = 0; m_miss = 0; end
                 end
      endcase
    end
    if (cap) m_word = prev_word;
    exp_vld = cap;
    if (m_state == 2) recov = 0;
    tl = pd_b ? "R7" : (!prev_good ? "R4" : "R2");
    tv = pd_b ? "R7" : (recov ? "R8" : (old != 2 ? "R3" : "R5"));
    chk("R1 word", word_o, m_word);
    chk({tl, " locked"}, W'(locked_o), W'(m_state == 2));
    chk({tv, " valid"}, W'(word_vld_o), W'(exp_vld));
    chk(pd_b ? "R7 wclk hold" : "R6 wclk high", W'(word_clk_o),
        W'(pd_b ? snap_wclk : (m_state != 0)));
  endtask

  // one period; pd_next is applied at slot 1 after the checks
  task automatic send_word(input logic [W-1:0] w, input bit good, input bit pd_next);
    for (int s = 0; s < SLOTS; s++) begin
      @(negedge clk);
      if (s == 0) pd_b = !pwr_n;
      if (s == 1) begin
        model_step();
        if (pd_next && pwr_n) snap_wclk = word_clk_o;
        if (!pd_next && !pwr_n) recov = 1;
        pwr_n = !pd_next;
      end
      if (s == 5) begin
        chk(!pwr_n ? "R7 wclk hold" : "R6 wclk low", W'(word_clk_o),
            W'(!pwr_n ? snap_wclk : 1'b0));
        chk(!pwr_n ? "R7 valid" : "R5 valid span", W'(word_vld_o),
            W'(!pwr_n ? 1'b0 : exp_vld));
      end
      for (int l = 0; l < LANES; l++) ser_lane_i[l] = w[l*SLOTS + s];
      fwd_clk_lane_i = clk_bit(good, s);
    end
    prev_word = w;
    prev_good = good;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk("R9 word", word_o, '0);
    chk("R9 flags", W'({word_clk_o, word_vld_o, locked_o}), '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after release", W'({word_clk_o, word_vld_o, locked_o}), '0);
    // lane mapping with walking ones
    for (int i = 0; i < W; i++) send_word(W'(1) << i, 1, 0);
    send_word(21'h0AAAAA, 1, 0);
    // single miss, then recovery
    send_word(21'h123456, 0, 0);
    send_word(21'h0F0F0F, 1, 0);
    send_word(21'h1FFFFF, 1, 0);
    // double miss drops lock, then relock
    send_word(21'h000001, 0, 0);
    send_word(21'h000002, 0, 0);
    for (int i = 0; i < 4; i++) send_word(W'($urandom), 1, 0);
    // miss while confirming
    send_word(21'h0, 0, 0); send_word(21'h0, 0, 0);
    send_word(21'h15555, 1, 0);
    send_word(21'h2AAAA, 0, 0);
    for (int i = 0; i < 4; i++) send_word(W'($urandom), 1, 0);
    // directed power-down while locked
    send_word(21'h135799, 1, 1);
    for (int i = 0; i < 3; i++) send_word(W'($urandom), 1, 1);
    for (int i = 0; i < 5; i++) send_word(W'($urandom), 1, 0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      int  r = int'($urandom_range(99));
      bit  g = (r >= 8);
      bit  pd = !pwr_n ? ($urandom_range(2) != 0) : ($urandom_range(99) < 3);
      send_word(W'($urandom), g, pd);
    end
    for (int i = 0; i < 4; i++) send_word(W'($urandom), 1, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule